// File: doc/BRIEF.md
# Address-Area Chip-Select and Wait-State Controller

This block sits between an internal bus master and the external memory pins. It looks at a 32-bit physical address, picks an external area from a 3-bit field inside that address, and runs one simple asynchronous bus cycle on that area. Three areas are served: area 3, area 4 and area 5. Each has its own chip select, its own bus-width setting and its own wait-count setting. A cycle drives an output-enable style read strobe or per-byte write strobes. The strobes stay active for a configurable number of extra cycles. The cycle ends with a one-cycle completion pulse.

The master presents an address, a direction and an access size, then raises a request while the block reports ready. All inputs are captured at that edge, and later changes have no effect until the next acceptance. Area 5 has a card mode. In card mode the lower half of the area is reported as memory-card space and the upper half as I/O-card space. Card mode also forbids longword bus width. Accesses that cannot be carried out finish at once with an error flag and drive no pins.

Top module: `area_cs_ctrl`

## Requirements
- R1: The area is taken from address bits 28..26. Code 011 selects area 3, 100 selects area 4 and 101 selects area 5. At most one of the three chip selects is ever active, and only the addressed area's select is active.
- R2: Address bits 31..29 do not affect any output. An address plus any multiple of 0x20000000 behaves exactly like the base address.
- R3: An accepted cycle runs in this order:
  - one setup cycle with only the chip select active;
  - 1+N cycles with the strobe active;
  - one cycle with `done` high, chip select and strobe still active;
  - then every output drops and `ready` returns the cycle after.
- R4: For area 3, N equals the 2-bit wait code, giving 0 to 3.
- R5: For area 4, the 3-bit wait code 0..7 gives N = 0, 1, 2, 3, 4, 6, 8, 10.
- R6: For area 5, N equals the 2-bit wait code, giving 0 to 3.
- R7: A read (`wr`=0) drives `rd_en` and no write lanes. A write (`wr`=1) drives the lane mask and never `rd_en`.
- R8: Widths and access sizes share one encoding: 00 byte, 01 word (2 bytes), 10 longword (4 bytes). The write mask covers the access bytes starting at lane (`addr` mod bus bytes). Lane 0 is the least significant byte, and only lanes inside the configured bus are used.
- R9: An access is rejected in any of these cases:
  - the area code is not 3, 4 or 5;
  - the width or size code is 11;
  - the size is wider than the bus;
  - `addr` is not a multiple of the access size.

  A rejected access raises `done` and `err` together in the cycle after acceptance, with no chip select, strobe or card flag, and the block is ready again one cycle later.
- R10: With `card_mode` set, an area-5 cycle raises `card_mem` when address bit 25 is 0 and `card_io` when it is 1. The flag is held for the whole cycle, setup through done. Without card mode, or for other areas, both flags stay low.
- R11: With `card_mode` set, an area-5 access whose bus width is configured as longword is rejected as in R9.
- R12: While `ready` is low, `req` and every other input are ignored. The running cycle continues with the values captured at acceptance.
- R13: During and right after reset, `ready` is high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a cycle; accepted when `ready` is high |
| addr | input | 32 | Physical address of the access |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| card_mode | input | 1 | Area 5 card-interface mode |
| a3_width | input | 2 | Area 3 bus width code |
| a3_wait | input | 2 | Area 3 wait code |
| a4_width | input | 2 | Area 4 bus width code |
| a4_wait | input | 3 | Area 4 wait code |
| a5_width | input | 2 | Area 5 bus width code |
| a5_wait | input | 2 | Area 5 wait code |
| ready | output | 1 | Idle and able to accept `req` |
| area3_sel | output | 1 | Area 3 chip select |
| area4_sel | output | 1 | Area 4 chip select |
| area5_sel | output | 1 | Area 5 chip select |
| rd_en | output | 1 | Read strobe, usable as output enable |
| wr_lane | output | 4 | Per-byte write strobes, bit 0 = least significant lane |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected access, valid with `done` |
| card_mem | output | 1 | Area 5 memory-card half in card mode |
| card_io | output | 1 | Area 5 I/O-card half in card mode |

## Verification
The embedded properties check these rules on every clock:
- the chip selects are one-hot or idle;
- read and write strobes never overlap, and neither appears without a chip select;
- an error never comes with a chip select;
- the card flags only accompany area 5;
- `done` lasts one cycle and is followed by `ready`;
- the chip select holds steady through a running cycle.

Some behaviour can only be shown by the bench's scenarios, which compare every output on every cycle against a behavioural model. This covers the exact length of each cycle for every wait code of every area, and the stepped area-4 mapping. It also covers the lane masks for every width, size and offset combination, shadow aliasing across all eight upper-bit values, the card halves, and mid-cycle input changes being ignored.

// File: rtl/area_cs_pkg.sv
package area_cs_pkg;

   typedef enum logic [1:0] {
      XFER_BYTE = 2'd0,
      XFER_WORD = 2'd1,
      XFER_LONG = 2'd2,
      XFER_RSVD = 2'd3
   } xfer_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_DONE
   } bus_state_t;

   localparam int FIRST_AREA = 3;
   localparam int NUM_AREAS  = 3;

endpackage

// File: rtl/area_decode.sv
module area_decode
   import area_cs_pkg::*;
#(
   parameter int FIELD_W = 3,
   parameter int BASE    = FIRST_AREA,
   parameter int COUNT   = NUM_AREAS
) (
   input  logic [FIELD_W-1:0] area_field,
   output logic [COUNT-1:0]   hit
);

   if (BASE + COUNT > (1 << FIELD_W)) begin : g_range_chk
      $error("area_decode: served areas exceed the field range");
   end

   for (genvar k = 0; k < COUNT; k++) begin : g_hit
      localparam logic [FIELD_W-1:0] CODE = FIELD_W'(BASE + k);
      assign hit[k] = (area_field == CODE);
   end

endmodule

// File: rtl/wait_lookup.sv
module wait_lookup #(
   parameter int CODE_W  = 3,
   parameter int CNT_W   = 4,
   parameter bit STEPPED = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  count
);

   localparam int KNEE      = 1 << (CODE_W - 1);
   localparam int MAX_CODE  = (1 << CODE_W) - 1;
   localparam int MAX_COUNT = STEPPED ? 2 * (MAX_CODE - KNEE / 2) : MAX_CODE;

   if (MAX_COUNT >= (1 << CNT_W)) begin : g_fit_chk
      $error("wait_lookup: counter too narrow for the largest wait");
   end

   if (STEPPED) begin : g_stepped
      // Linear up to the knee, then steps of two cycles.
      always_comb begin
         if (int'(code) < KNEE) count = CNT_W'(code);
         else                   count = CNT_W'(2 * (int'(code) - KNEE / 2));
      end
   end else begin : g_linear
      assign count = CNT_W'(code);
   end

endmodule

// File: rtl/lane_mask.sv
module lane_mask
   import area_cs_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int LANE_AW = $clog2(LANES)
) (
   input  logic [1:0]         bus_w,
   input  logic [1:0]         acc_w,
   input  logic [LANE_AW-1:0] addr_lo,
   output logic [LANES-1:0]   mask,
   output logic               bad
);

   localparam int BW = LANE_AW + 1;

   if (LANES != 4) begin : g_lane_chk
      $error("lane_mask: width codes only reach four lanes");
   end

   logic [BW-1:0] bus_b, acc_b, lo, off;

   always_comb begin
      bus_b = BW'(1) << bus_w;
      acc_b = BW'(1) << acc_w;
      lo    = {1'b0, addr_lo};
      off   = lo & (bus_b - BW'(1));
      bad   = (bus_w == XFER_RSVD) || (acc_w == XFER_RSVD) ||
              (acc_b > bus_b) || ((lo & (acc_b - BW'(1))) != '0);
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = !bad && (BW'(i) >= off) && (BW'(i) < off + acc_b);
   end

endmodule

// File: rtl/area_cs_ctrl.sv
module area_cs_ctrl
   import area_cs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LANES     = 4,
   parameter int AREA_LSB  = 26,
   parameter int SPLIT_BIT = 25,
   parameter int A4_CODE_W = 3,
   parameter int MAX_WAIT  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic              card_mode,
   input  logic [1:0]        a3_width,
   input  logic [1:0]        a3_wait,
   input  logic [1:0]        a4_width,
   input  logic [2:0]        a4_wait,
   input  logic [1:0]        a5_width,
   input  logic [1:0]        a5_wait,
   output logic              ready,
   output logic              area3_sel,
   output logic              area4_sel,
   output logic              area5_sel,
   output logic              rd_en,
   output logic [LANES-1:0]  wr_lane,
   output logic              done,
   output logic              err,
   output logic              card_mem,
   output logic              card_io
);

   localparam int CNT_W   = $clog2(MAX_WAIT + 1);
   localparam int LANE_AW = $clog2(LANES);
   localparam int FIELD_W = 3;

   if (AREA_LSB + FIELD_W > ADDR_W) begin : g_addr_chk
      $error("area_cs_ctrl: area field outside the address");
   end
   if (SPLIT_BIT >= AREA_LSB || SPLIT_BIT < LANE_AW) begin : g_split_chk
      $error("area_cs_ctrl: card split bit must lie below the area field");
   end

   // ---------------- decode of the request ----------------
   logic [NUM_AREAS-1:0] hit;
   logic [1:0]           bus_w;
   logic [LANES-1:0]     mask;
   logic                 lane_bad, card_long, reject;
   logic [CNT_W-1:0]     w3, w4, w5, wsel;

   area_decode #(.FIELD_W(FIELD_W)) u_dec (
      .area_field (addr[AREA_LSB +: FIELD_W]),
      .hit        (hit)
   );

   always_comb begin
      unique case (1'b1)
         hit[0]:  bus_w = a3_width;
         hit[1]:  bus_w = a4_width;
         hit[2]:  bus_w = a5_width;
         default: bus_w = XFER_BYTE;
      endcase
   end

   lane_mask #(.LANES(LANES)) u_lanes (
      .bus_w   (bus_w),
      .acc_w   (size),
      .addr_lo (addr[LANE_AW-1:0]),
      .mask    (mask),
      .bad     (lane_bad)
   );

   wait_lookup #(.CODE_W(2), .CNT_W(CNT_W), .STEPPED(1'b0)) u_w3 (
      .code (a3_wait), .count (w3)
   );
   wait_lookup #(.CODE_W(A4_CODE_W), .CNT_W(CNT_W), .STEPPED(1'b1)) u_w4 (
      .code (a4_wait), .count (w4)
   );
   wait_lookup #(.CODE_W(2), .CNT_W(CNT_W), .STEPPED(1'b0)) u_w5 (
      .code (a5_wait), .count (w5)
   );

   always_comb begin
      unique case (1'b1)
         hit[0]:  wsel = w3;
         hit[1]:  wsel = w4;
         hit[2]:  wsel = w5;
         default: wsel = '0;
      endcase
      card_long = hit[2] && card_mode && (a5_width == XFER_LONG);
      reject    = !(|hit) || lane_bad || card_long;
   end

   // ---------------- cycle sequencer ----------------
   bus_state_t            state;
   logic [CNT_W-1:0]      cnt;
   logic [NUM_AREAS-1:0]  cs_q;
   logic [LANES-1:0]      mask_q;
   logic                  wr_q, err_q, cmem_q, cio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         cs_q   <= '0;
         mask_q <= '0;
         wr_q   <= 1'b0;
         err_q  <= 1'b0;
         cmem_q <= 1'b0;
         cio_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req) begin
               wr_q   <= wr;
               mask_q <= mask;
               cnt    <= wsel;
               if (reject) begin
                  state <= ST_DONE;
                  err_q <= 1'b1;
               end else begin
                  state  <= ST_SETUP;
                  err_q  <= 1'b0;
                  cs_q   <= hit;
                  cmem_q <= hit[2] && card_mode && !addr[SPLIT_BIT];
                  cio_q  <= hit[2] && card_mode &&  addr[SPLIT_BIT];
               end
            end
            ST_SETUP: state <= ST_STROBE;
            ST_STROBE: begin
               if (cnt == '0) state <= ST_DONE;
               else           cnt   <= cnt - CNT_W'(1);
            end
            ST_DONE: begin
               state  <= ST_IDLE;
               cs_q   <= '0;
               err_q  <= 1'b0;
               cmem_q <= 1'b0;
               cio_q  <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic strobe_on;
   assign strobe_on = (state == ST_STROBE) || (state == ST_DONE && !err_q);

   assign ready     = (state == ST_IDLE);
   assign done      = (state == ST_DONE);
   assign err       = done && err_q;
   assign area3_sel = cs_q[0];
   assign area4_sel = cs_q[1];
   assign area5_sel = cs_q[2];
   assign rd_en     = strobe_on && !wr_q;
   assign wr_lane   = (strobe_on && wr_q) ? mask_q : '0;
   assign card_mem  = cmem_q;
   assign card_io   = cio_q;

   // ---------------- embedded checks ----------------
   // R1
   one_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({area3_sel, area4_sel, area5_sel}));

   // R1
   addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |-> (^addr !== 1'bx));

   // R7
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && (|wr_lane)));

   // R3
   strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || (|wr_lane)) |-> (area3_sel || area4_sel || area5_sel));

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

   // R3
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !(area3_sel || area4_sel || area5_sel || rd_en || (|wr_lane) || card_mem || card_io));

   // R10
   card_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_mem || card_io) |-> (area5_sel && !(card_mem && card_io)));

   // R12
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !done) |=> $stable({area3_sel, area4_sel, area5_sel}));

endmodule

// File: tb/area_cs_ctrl_test.sv
module area_cs_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req, wr, card_mode;
   logic [31:0] addr;
   logic [1:0]  size, a3_width, a3_wait, a4_width, a5_width, a5_wait;
   logic [2:0]  a4_wait;
   logic        ready, area3_sel, area4_sel, area5_sel, rd_en, done, err, card_mem, card_io;
   logic [3:0]  wr_lane;

   always #5 clk = ~clk;

   area_cs_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr), .size(size),
      .card_mode(card_mode), .a3_width(a3_width), .a3_wait(a3_wait),
      .a4_width(a4_width), .a4_wait(a4_wait), .a5_width(a5_width), .a5_wait(a5_wait),
      .ready(ready), .area3_sel(area3_sel), .area4_sel(area4_sel), .area5_sel(area5_sel),
      .rd_en(rd_en), .wr_lane(wr_lane), .done(done), .err(err),
      .card_mem(card_mem), .card_io(card_io)
   );

   // {ready, cs3, cs4, cs5, rd_en, wr_lane[3:0], done, err, card_mem, card_io}
   localparam logic [12:0] IDLE_V = 13'b1_000_0_0000_00_00;

   logic [12:0] exp_q[$];
   int          vectors = 0;
   int          fails   = 0;
   string       cur_req = "R13";
   bit          finished = 0;

   task automatic tick();
      logic [12:0] got, exp;
      @(negedge clk);
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
      got = {ready, area3_sel, area4_sel, area5_sel, rd_en, wr_lane, done, err, card_mem, card_io};
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s at %0t: got %b expected %b", cur_req, $time, got, exp);
      end
   endtask

   // Build the expected trace from the requirements, then drive the request.
   task automatic issue(input logic [31:0] a, input logic w, input logic [1:0] sz, input bit hold);
      int area, wdt, bus, acc, off, nwait;
      bit bad;
      logic [3:0] m;
      logic c3, c4, c5, cm, ci;
      area = int'(a[28:26]);
      case (area)
         3: wdt = int'(a3_width);
         4: wdt = int'(a4_width);
         5: wdt = int'(a5_width);
         default: wdt = 0;
      endcase
      bad = !(area == 3 || area == 4 || area == 5) || wdt == 3 || sz == 2'd3;
      bus = 1; acc = 1; off = 0;
      if (!bad) begin
         bus = 1 << wdt;
         acc = 1 << int'(sz);
         if (acc > bus || (int'(a[1:0]) % acc) != 0) bad = 1;
         off = int'(a[1:0]) % bus;
      end
      if (area == 5 && card_mode && wdt == 2) bad = 1;
      m = '0;
      for (int i = 0; i < 4; i++) if (i >= off && i < off + acc) m[i] = 1'b1;
      case (area)
         3: nwait = int'(a3_wait);
         4: case (a4_wait)
               3'd4: nwait = 4;
               3'd5: nwait = 6;
               3'd6: nwait = 8;
               3'd7: nwait = 10;
               default: nwait = int'(a4_wait);
            endcase
         default: nwait = int'(a5_wait);
      endcase
      c3 = (area == 3); c4 = (area == 4); c5 = (area == 5);
      cm = c5 && card_mode && !a[25];
      ci = c5 && card_mode &&  a[25];
      if (bad) begin
         exp_q.push_back(13'b0_000_0_0000_11_00);
      end else begin
         exp_q.push_back({1'b0, c3, c4, c5, 1'b0, 4'b0, 2'b00, cm, ci});
         for (int k = 0; k <= nwait; k++)
            exp_q.push_back({1'b0, c3, c4, c5, !w, (w ? m : 4'b0), 2'b00, cm, ci});
         exp_q.push_back({1'b0, c3, c4, c5, !w, (w ? m : 4'b0), 2'b10, cm, ci});
      end
      addr = a; wr = w; size = sz; req = 1'b1;
      tick();
      if (hold) begin
         // R12: scramble the request inputs while busy
         addr = {3'b111, 3'b100, 26'h0000002}; wr = ~w; size = 2'd1;
      end else begin
         req = 1'b0;
      end
      while (exp_q.size() > 0) tick();
      req = 1'b0;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; addr = '0; wr = 1'b0; size = 2'd0; card_mode = 1'b0;
      a3_width = 2'd2; a3_wait = 2'd0; a4_width = 2'd2; a4_wait = 3'd0;
      a5_width = 2'd2; a5_wait = 2'd0;

      // R13: reset state
      cur_req = "R13";
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (2) tick();

      // R4: area 3 wait codes, reads and writes
      cur_req = "R4";
      for (int c = 0; c < 4; c++) begin
         a3_wait = 2'(c);
         issue(32'h0C00_0010, 1'b0, 2'd2, 0);
         issue(32'h0C00_0014, 1'b1, 2'd2, 0);
      end

      // R5: area 4 stepped wait mapping
      cur_req = "R5";
      for (int c = 0; c < 8; c++) begin
         a4_wait = 3'(c);
         issue(32'h1000_0100, 1'b0, 2'd1, 0);
      end

      // R6: area 5 wait codes
      cur_req = "R6";
      for (int c = 0; c < 4; c++) begin
         a5_wait = 2'(c);
         issue(32'h1400_0040, 1'b1, 2'd0, 0);
      end

      // R2: shadow copies through every upper-bit value
      cur_req = "R2";
      a3_wait = 2'd1; a4_wait = 3'd2; a5_wait = 2'd1;
      for (int n = 0; n < 8; n++) begin
         issue({3'(n), 29'h0C00_0008}, 1'b1, 2'd0, 0);
         issue({3'(n), 29'h1000_0004}, 1'b0, 2'd2, 0);
         issue({3'(n), 29'h1400_0002}, 1'b1, 2'd1, 0);
      end

      // R1 / R9: areas outside 3..5 are rejected
      cur_req = "R1";
      issue(32'h0C12_3450, 1'b0, 2'd0, 0);
      cur_req = "R9";
      for (int ar = 0; ar < 8; ar++)
         if (ar < 3 || ar > 5) issue({3'b010, 3'(ar), 26'h0000_100}, 1'b1, 2'd0, 0);

      // R7 / R8 / R9: every width, size and offset on area 3
      a3_wait = 2'd0;
      for (int wd = 0; wd < 4; wd++)
         for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 4; lo++) begin
               a3_width = 2'(wd);
               cur_req = "R8";
               issue({30'h0300_0020, 2'(lo)}, 1'b1, 2'(sz), 0);
               cur_req = "R7";
               issue({30'h0300_0020, 2'(lo)}, 1'b0, 2'(sz), 0);
            end
      a3_width = 2'd2;

      // R10: card halves of area 5
      cur_req = "R10";
      card_mode = 1'b1; a5_width = 2'd1; a5_wait = 2'd2;
      issue(32'h1400_0000, 1'b0, 2'd1, 0);
      issue(32'h1600_0006, 1'b1, 2'd1, 0);
      issue(32'h7600_0001, 1'b1, 2'd0, 0);
      a5_width = 2'd0;
      issue(32'h1500_0003, 1'b0, 2'd0, 0);
      issue(32'h1000_0000, 1'b0, 2'd0, 0);

      // R11: longword bus width forbidden in card mode
      cur_req = "R11";
      a5_width = 2'd2;
      issue(32'h1400_0000, 1'b0, 2'd0, 0);
      issue(32'h1600_0004, 1'b1, 2'd2, 0);
      card_mode = 1'b0;
      issue(32'h1600_0004, 1'b1, 2'd2, 0);

      // R12: request and inputs changed while busy are ignored
      cur_req = "R12";
      a4_wait = 3'd7;
      issue(32'h1000_0008, 1'b1, 2'd2, 1);
      a3_wait = 2'd3;
      issue(32'h0C00_0001, 1'b0, 2'd0, 1);
      issue(32'h1800_0000, 1'b0, 2'd0, 1);

      // R3: back-to-back cycles return to ready between them
      cur_req = "R3";
      a4_wait = 3'd0;
      issue(32'h1000_0000, 1'b1, 2'd2, 0);
      issue(32'h1000_0004, 1'b0, 2'd2, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule